// File: doc/BRIEF.md
# SPI flash user-mode engine

This block lets a host run a serial NOR flash by hand, one byte at a time. The host sets up a control register. It then opens a frame by clearing a stop bit while the command mode is user. After that, every write to the data window sends its bytes out on a single-lane SPI bus, and every read from the window clocks bytes in. Setting the stop bit again closes the frame. The window has no address: it acts as a FIFO, so the position of an access inside it has no effect.

The host bus is a simple request/ready interface. It carries a register/window select, a size code and 32-bit data. A register access completes in the cycle it is requested. A window access holds `ready_o` low until all of its bytes have been shifted. The block generates SCLK from a programmable divider. It also enforces a minimum chip-select high time between frames, and it supports clock mode 0 or 3 and MSB-first or LSB-first bit order. A per-chip write-enable bit in a config register guards the window against writes.

Top module: `spi_um_engine`

## Requirements
- R1: After reset, `cs_no` is high, `sclk_o` and `mosi_o` are low, the control register reads 0x00000004 and the config register reads 0.
- R2: `cs_no` goes low only while the control mode field [1:0] equals 3 (user) and the stop bit [2] is 0. A window access made while the frame is closed completes in the same cycle with no SCLK edge, and a read returns 0.
- R3: Let F be the gap field at control bits [27:24]. Once `cs_no` rises it stays high for at least 16−F cycles. If the frame is reopened at once, it stays high for exactly 16−F cycles.
- R4: A window write with size code `size_i` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes) sends the bytes in the order wdata[7:0], wdata[15:8] and so on. When control bit 5 is 0, each byte goes out MSB first.
- R5: During a window read `mosi_o` stays low. The first byte received is returned in rdata[7:0], the next in rdata[15:8], and so on.
- R6: The write-enable bit sits at config bit 16+CHIP_IDX (bit 16 by default). While it is 0, window writes are acknowledged in the same cycle and produce no SCLK edge.
- R7: When control bit 4 is 1, SCLK idles high (mode 3). When it is 0, SCLK idles low (mode 0). In both modes MISO is sampled on the rising edge.
- R8: When control bit 5 is 1, each byte is sent and received LSB first.
- R9: With N in the divider field at control bits [11:8], each SCLK half period lasts N+1 clock cycles.
- R10: A window access raises `ready_o` only after 8 rising SCLK edges per byte have occurred. Register accesses are acknowledged in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request, held until `ready_o` |
| we_i | input | 1 | 1 = write, 0 = read |
| win_i | input | 1 | 1 = data window, 0 = register |
| reg_sel_i | input | 1 | Register select: 0 = config, 1 = control |
| size_i | input | 2 | Window access size code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while `ready_o` is high |
| ready_o | output | 1 | Access completes on this cycle |
| sclk_o | output | 1 | SPI clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its defaults: 32-bit data, chip index 0 and a write-enable bit at config bit 16. It uses divider values 1 and 2, so SCLK half periods of more than one cycle are exercised. It uses gap fields 0, 12 and 15, which reach both ends of the chip-select gap (16 cycles and 1 cycle). Transfers of 1, 2 and 4 bytes are run in both clock modes and both bit orders, and the bench compares them against a serial slave model and a per-cycle model of the idle levels.

// File: rtl/spi_um_pkg.sv
package spi_um_pkg;
  localparam int DIV_W = 4;
  localparam int GAP_W = 4;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_FREAD  = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_USER   = 2'd3
  } cmd_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SHIFT,
    ST_DONE
  } host_st_e;

  typedef struct packed {
    logic [GAP_W-1:0] gap;
    logic [DIV_W-1:0] div;
    logic             lsb;
    logic             cpol;
    logic             stop;
    cmd_mode_e        mode;
  } ctrl_t;
endpackage

// File: rtl/spi_um_regs.sv
module spi_um_regs
  import spi_um_pkg::*;
#(
  parameter int DW       = 32,
  parameter int WE_BASE  = 16,
  parameter int CHIP_IDX = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          sel_ctrl_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output ctrl_t         ctrl_o,
  output logic          we_bit_o
);
  localparam int WE_POS = WE_BASE + CHIP_IDX;
  localparam logic [DW-1:0] CTRL_RST = DW'(32'h4);

  logic [DW-1:0] cfg_q, ctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
      ctl_q <= CTRL_RST;
    end else if (wr_en_i) begin
      if (sel_ctrl_i) ctl_q <= wdata_i;
      else            cfg_q <= wdata_i;
    end
  end

  always_comb begin
    ctrl_o.mode = cmd_mode_e'(ctl_q[1:0]);
    ctrl_o.stop = ctl_q[2];
    ctrl_o.cpol = ctl_q[4];
    ctrl_o.lsb  = ctl_q[5];
    ctrl_o.div  = ctl_q[8 +: DIV_W];
    ctrl_o.gap  = ctl_q[24 +: GAP_W];
  end

  assign we_bit_o = cfg_q[WE_POS];
  assign rdata_o  = sel_ctrl_i ? ctl_q : cfg_q;
endmodule

// File: rtl/spi_um_cs.sv
module spi_um_cs #(
  parameter int GAP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             open_i,
  input  logic [GAP_W-1:0] gap_field_i,
  output logic             cs_no
);
  logic [GAP_W-1:0] gap_q;
  logic             low_q;
  logic             cs_low;

  // field F gives 16-F high cycles: count ~F after the first high cycle
  assign cs_low = open_i && (gap_q == '0);
  assign cs_no  = !cs_low;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
      low_q <= 1'b0;
    end else begin
      low_q <= cs_low;
      if (low_q && !cs_low)  gap_q <= ~gap_field_i;
      else if (gap_q != '0)  gap_q <= gap_q - 1'b1;
    end
  end

  assert_cs_gap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_q && cs_no && gap_field_i != '1) |=> cs_no);
endmodule

// File: rtl/spi_um_shift.sv
module spi_um_shift #(
  parameter int DW    = 32,
  parameter int DIV_W = 4,
  localparam int NB   = DW / 8,
  localparam int BC_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic             lsb_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [BC_W-1:0]  nb_m1_i,
  input  logic [DW-1:0]    tx_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             phase_o,
  output logic             mosi_o,
  output logic [DW-1:0]    rx_o
);
  logic             busy_q, half_q, done_q, rd_q, lsb_q;
  logic [DIV_W-1:0] div_q, div_cnt;
  logic [2:0]       bit_cnt;
  logic [BC_W-1:0]  byte_cnt, last_q;
  logic [7:0]       rx_byte, tx_byte;
  logic [DW-1:0]    tx_q, rx_q;
  logic [2:0]       bit_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; half_q <= 1'b0; done_q <= 1'b0;
      rd_q <= 1'b0; lsb_q <= 1'b0; div_q <= '0; div_cnt <= '0;
      bit_cnt <= '0; byte_cnt <= '0; last_q <= '0;
      rx_byte <= '0; tx_q <= '0; rx_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1; half_q <= 1'b0;
        div_q <= div_i; div_cnt <= div_i;
        bit_cnt <= '0; byte_cnt <= '0; last_q <= nb_m1_i;
        tx_q <= tx_i; rx_q <= '0; rd_q <= rd_i; lsb_q <= lsb_i;
      end else if (busy_q) begin
        if (div_cnt != '0) begin
          div_cnt <= div_cnt - 1'b1;
        end else begin
          div_cnt <= div_q;
          if (!half_q) begin
            half_q  <= 1'b1;
            rx_byte <= lsb_q ? {miso_i, rx_byte[7:1]} : {rx_byte[6:0], miso_i};
          end else begin
            half_q  <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == 3'd7) begin
              rx_q[{byte_cnt, 3'b000} +: 8] <= rx_byte;
              if (byte_cnt == last_q) begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end else begin
                byte_cnt <= byte_cnt + 1'b1;
              end
            end
          end
        end
      end
    end
  end

  assign tx_byte = tx_q[{byte_cnt, 3'b000} +: 8];
  assign bit_idx = lsb_q ? bit_cnt : ~bit_cnt;
  assign mosi_o  = busy_q && !rd_q && tx_byte[bit_idx];
  assign busy_o  = busy_q;
  assign done_o  = done_q;
  assign phase_o = half_q;
  assign rx_o    = rx_q;

  assert_half_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !start_i && div_cnt != '0) |=> $stable(half_q));
endmodule

// File: rtl/spi_um_engine.sv
module spi_um_engine
  import spi_um_pkg::*;
#(
  parameter int DW       = 32,
  parameter int WE_BASE  = 16,
  parameter int CHIP_IDX = 0,
  localparam int NB      = DW / 8,
  localparam int BC_W    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          win_i,
  input  logic          reg_sel_i,
  input  logic [1:0]    size_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o,
  output logic          sclk_o,
  output logic          cs_no,
  output logic          mosi_o,
  input  logic          miso_i
);
  host_st_e      state_q, state_d;
  ctrl_t         ctrl;
  logic          we_bit, open, imm_ack, go, start;
  logic          sh_busy, sh_done, sh_phase;
  logic [DW-1:0] reg_rdata, rx_word;
  logic [BC_W-1:0] nb_m1;

  assign open    = (ctrl.mode == MODE_USER) && !ctrl.stop;
  assign imm_ack = (state_q == ST_IDLE) && req_i &&
                   (!win_i || !open || (we_i && !we_bit));
  assign go      = (state_q == ST_IDLE) && req_i && win_i && open && !(we_i && !we_bit);
  assign start   = (state_q == ST_WAIT) && !cs_no;
  assign nb_m1   = BC_W'((3'd1 << size_i) - 3'd1);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_WAIT;
      ST_WAIT:  if (start) state_d = ST_SHIFT;
      ST_SHIFT: if (sh_done) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  spi_um_regs #(.DW(DW), .WE_BASE(WE_BASE), .CHIP_IDX(CHIP_IDX)) u_regs (
    .clk_i, .rst_ni,
    .wr_en_i    (imm_ack && !win_i && we_i),
    .sel_ctrl_i (reg_sel_i),
    .wdata_i,
    .rdata_o    (reg_rdata),
    .ctrl_o     (ctrl),
    .we_bit_o   (we_bit)
  );

  spi_um_cs #(.GAP_W(GAP_W)) u_cs (
    .clk_i, .rst_ni,
    .open_i      (open),
    .gap_field_i (ctrl.gap),
    .cs_no       (cs_no)
  );

  spi_um_shift #(.DW(DW), .DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i (start),
    .rd_i    (!we_i),
    .lsb_i   (ctrl.lsb),
    .div_i   (ctrl.div),
    .nb_m1_i (nb_m1),
    .tx_i    (wdata_i),
    .miso_i,
    .busy_o  (sh_busy),
    .done_o  (sh_done),
    .phase_o (sh_phase),
    .mosi_o  (mosi_o),
    .rx_o    (rx_word)
  );

  assign ready_o = imm_ack || (state_q == ST_DONE);
  assign rdata_o = !win_i ? reg_rdata : ((state_q == ST_DONE) ? rx_word : '0);
  assign sclk_o  = sh_busy ? sh_phase : ctrl.cpol;

  assert_shift_in_frame_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> !cs_no);
  assert_busy_no_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sh_busy |-> !ready_o);
  assert_drop_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && req_i && win_i && we_i && open && !we_bit)
      |=> (state_q == ST_IDLE) && !sh_busy);
endmodule

// File: tb/spi_um_engine_test.sv
module spi_um_engine_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0, win = 1'b0, rsel = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        ready, sclk, cs_n, mosi, miso = 1'b0;

  always #4 clk = ~clk;

  spi_um_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .win_i(win),
    .reg_sel_i(rsel), .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .ready_o(ready), .sclk_o(sclk), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso)
  );

  int vectors = 0, miscompares = 0, cyc = 0;
  logic [63:0] cap;
  int cap_n, run, hi_run, last_hi, exp_half;
  bit run_bad, model_open, model_cpol, prev_sclk, prev_cs;
  bit mq[$];

  task automatic chk(bit ok, string req_tag, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req_tag, what, act, exp);
    end
  endtask

  // cycle-by-cycle monitor and serial slave model
  always @(negedge clk) begin
    if (rst_ni) begin
      if (cs_n) chk(sclk == model_cpol, "R7", "idle sclk level", 64'(sclk), 64'(model_cpol));
      if (!model_open) chk(cs_n == 1'b1, "R2", "cs while frame closed", 64'(cs_n), 64'd1);
      if (!cs_n && sclk && !prev_sclk) begin
        cap = (cap << 1) | 64'(mosi);
        cap_n++;
        if (mq.size() > 0) void'(mq.pop_front());
        miso = (mq.size() > 0) ? mq[0] : 1'b0;
      end
      if (sclk != model_cpol) run++;
      else if (run != 0) begin
        if (run != exp_half) run_bad = 1'b1;
        run = 0;
      end
      if (cs_n) hi_run++;
      else begin
        if (prev_cs) last_hi = hi_run;
        hi_run = 0;
      end
      prev_sclk = sclk;
      prev_cs   = cs_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic access(bit w, bit wi, bit rs, logic [1:0] sz, logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; win = wi; rsel = rs; size = sz; wdata = d;
    lat = 0;
    #1;
    while (!ready) begin
      @(negedge clk); #1; lat++;
    end
    rd = rdata;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  function automatic logic [31:0] ctl(int mode, bit stop, bit cpol, bit lsb, int dv, int gp);
    return 32'(mode) | (32'(stop) << 2) | (32'(cpol) << 4) | (32'(lsb) << 5) |
           (32'(dv) << 8) | (32'(gp) << 24);
  endfunction

  task automatic wr_ctl(logic [31:0] v);
    logic [31:0] r; int l;
    access(1'b1, 1'b0, 1'b1, 2'd0, v, r, l);
    model_open = (v[1:0] == 2'd3) && !v[2];
    model_cpol = v[4];
  endtask

  function automatic logic [63:0] stream(logic [31:0] d, int nb, bit lsb);
    logic [63:0] s = '0;
    for (int k = 0; k < nb; k++)
      for (int b = 0; b < 8; b++)
        s = (s << 1) | 64'(lsb ? d[8*k + b] : d[8*k + 7 - b]);
    return s;
  endfunction

  task automatic win_write(logic [1:0] sz, logic [31:0] d, bit lsb, int dv, string tag);
    logic [31:0] r; int l; int nb;
    nb = 1 << sz;
    cap = '0; cap_n = 0; run_bad = 1'b0; exp_half = dv + 1;
    access(1'b1, 1'b1, 1'b0, sz, d, r, l);
    chk(cap_n == 8*nb, "R10", "rising edges before ready", 64'(cap_n), 64'(8*nb));
    chk(l >= nb*16*(dv+1), "R10", "ready latency lower bound", 64'(l), 64'(nb*16*(dv+1)));
    chk(cap == stream(d, nb, lsb), tag, "bit stream sent", cap, stream(d, nb, lsb));
    chk(!run_bad, "R9", "sclk half period", 64'(run_bad), 64'd0);
  endtask

  task automatic win_read(logic [1:0] sz, logic [31:0] d, bit lsb, int dv, string tag);
    logic [31:0] r; int l; int nb;
    nb = 1 << sz;
    mq.delete();
    for (int k = 0; k < nb; k++)
      for (int b = 0; b < 8; b++)
        mq.push_back(lsb ? d[8*k + b] : d[8*k + 7 - b]);
    miso = mq[0];
    cap = '0; cap_n = 0; run_bad = 1'b0; exp_half = dv + 1;
    access(1'b0, 1'b1, 1'b0, sz, 32'hFFFF_FFFF, r, l);
    chk(cap == 64'd0, "R5", "mosi low during read", cap, 64'd0);
    chk(cap_n == 8*nb, "R10", "read edges before ready", 64'(cap_n), 64'(8*nb));
    chk(r == d, tag, "read data", 64'(r), 64'(d));
    chk(!run_bad, "R9", "sclk half period on read", 64'(run_bad), 64'd0);
  endtask

  task automatic gap_case(int gp);
    wr_ctl(ctl(3, 1'b1, 1'b0, 1'b0, 1, gp));
    wr_ctl(ctl(3, 1'b0, 1'b0, 1'b0, 1, gp));
    win_write(2'd0, 32'h5A, 1'b0, 1, "R4");
    chk(last_hi == 16 - gp, "R3", "cs high time", 64'(last_hi), 64'(16 - gp));
  endtask

  initial begin
    logic [31:0] r; int l;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk(cs_n == 1'b1, "R1", "cs after reset", 64'(cs_n), 64'd1);
    chk(sclk == 1'b0, "R1", "sclk after reset", 64'(sclk), 64'd0);
    chk(mosi == 1'b0, "R1", "mosi after reset", 64'(mosi), 64'd0);
    access(1'b0, 1'b0, 1'b1, 2'd0, '0, r, l);
    chk(r == 32'h4, "R1", "control reset value", 64'(r), 64'h4);
    access(1'b0, 1'b0, 1'b0, 2'd0, '0, r, l);
    chk(r == 32'h0, "R1", "config reset value", 64'(r), 64'h0);
    chk(l == 0, "R10", "register ack latency", 64'(l), 64'd0);

    // open frame with write enable still clear: writes dropped
    wr_ctl(ctl(3, 1'b1, 1'b0, 1'b0, 1, 0));
    wr_ctl(ctl(3, 1'b0, 1'b0, 1'b0, 1, 0));
    cap_n = 0;
    access(1'b1, 1'b1, 1'b0, 2'd0, 32'hFF, r, l);
    chk(l == 0, "R6", "dropped write latency", 64'(l), 64'd0);
    chk(cap_n == 0, "R6", "dropped write edges", 64'(cap_n), 64'd0);

    access(1'b1, 1'b0, 1'b0, 2'd0, 32'h0001_0000, r, l);
    win_write(2'd0, 32'hA5, 1'b0, 1, "R4");
    win_write(2'd2, 32'h4433_2211, 1'b0, 1, "R4");
    win_write(2'd1, 32'h0000_80F1, 1'b0, 1, "R4");
    win_read(2'd1, 32'h0000_C33C, 1'b0, 1, "R5");
    win_read(2'd2, 32'h1234_5678, 1'b0, 1, "R5");

    gap_case(12);
    gap_case(0);
    gap_case(15);

    // mode 3, divider 2
    wr_ctl(ctl(3, 1'b1, 1'b1, 1'b0, 2, 15));
    wr_ctl(ctl(3, 1'b0, 1'b1, 1'b0, 2, 15));
    win_write(2'd0, 32'h81, 1'b0, 2, "R7");
    win_read(2'd0, 32'h96, 1'b0, 2, "R7");

    // LSB first, mode 0
    wr_ctl(ctl(3, 1'b1, 1'b0, 1'b1, 1, 15));
    wr_ctl(ctl(3, 1'b0, 1'b0, 1'b1, 1, 15));
    win_write(2'd1, 32'h0000_0301, 1'b1, 1, "R8");
    win_read(2'd0, 32'h5A, 1'b1, 1, "R8");

    // closed frame: stop set in user mode, then normal mode
    wr_ctl(ctl(3, 1'b1, 1'b0, 1'b0, 1, 15));
    cap_n = 0;
    access(1'b1, 1'b1, 1'b0, 2'd0, 32'h33, r, l);
    chk(l == 0 && cap_n == 0, "R2", "write with stop set", 64'(cap_n), 64'd0);
    wr_ctl(ctl(0, 1'b0, 1'b0, 1'b0, 1, 15));
    mq.delete(); miso = 1'b1;
    access(1'b0, 1'b1, 1'b0, 2'd2, '0, r, l);
    chk(r == 32'h0 && cap_n == 0 && l == 0, "R2", "read in normal mode", 64'(r), 64'd0);
    access(1'b0, 1'b0, 1'b0, 2'd0, '0, r, l);
    chk(r == 32'h0001_0000, "R6", "config readback", 64'(r), 64'h0001_0000);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule